// File: doc/BRIEF.md
# Linked command list executor

This block walks a chain of command descriptors kept in system memory and carries out each one in turn. A descriptor sits at a 16-bit-word-aligned byte address. It holds a status word, a command word, a 32-bit link to the next descriptor and, from offset 8 on, a parameter area whose meaning depends on the opcode. For every descriptor the block first marks the status word busy. It then fetches the command word and the link, performs the operation and writes the completion status. Finally it follows the link, unless the command word or the link itself ends the list.

The supported operations are: load of the station address, load of the configuration table (with forced bit fixups), a link test that writes the current link state back into the descriptor, and transmit. Transmit walks a chain of buffer descriptors and hands one (address, length) request per non-empty buffer to a downstream DMA engine, which moves the data. The other opcodes only complete with an OK status. A start pulse either begins a new list or resumes a list that a suspend bit halted.

Top module: `cmd_list_exec`

## Requirements
- R1: After synchronous reset the unit state is idle (0), `mem_req`, `dma_valid`, `irq` and `done_flag` are 0, and the station address and all configuration bytes are zero.
- R2: Memory is accessed in 16-bit words. A request holds its address, direction and write data unchanged until `mem_ack`. A 32-bit field has its low half at address a and its high half at a+2. The byte at an even address is bits 15:8 of that word.
- R3: For each descriptor at address p, the first access writes 0x4000 to p. Then come the reads of the command word at p+2 and the link at p+4/p+6, then the operation's own accesses. The last access writes 0xA000 to p.
- R4: The opcode is bits 2:0 of the command word: 1 address load, 2 configure, 4 transmit, 5 link test. Codes 0, 3, 6 and 7 perform no operation beyond the two status writes.
- R5: Address load reads three words from p+8, p+10 and p+12. `ia_addr` becomes {word0, word1, word2}, so the byte at p+8 lands in bits 47:40.
- R6: Configure takes the count from bits 3:0 of the byte at p+8 and clamps it to between 4 and 14. It copies that many bytes from p+8 on into table byte i (`cfg_flat[8*i +: 8]`), and leaves bytes at and above the count unchanged.
- R7: After each configure, byte 2 becomes (byte2 AND 0x82) OR 0x40. Byte 7 loses bit 3. Byte 10 is raised to at least 5. Byte 12 keeps only bit 6. Byte 13 gets bits 5:0 set.
- R8: Link test writes 0x8000 (link up) or 0x0000 (link down) to p+8 and 0x0000 to p+10.
- R9: Transmit reads the first buffer descriptor pointer from p+8. Each buffer descriptor t holds a size word at t (bit 15 last buffer, bits 13:0 length), a next link at t+4 and a buffer address at t+8. Each buffer with a non-zero length yields one DMA request, in chain order. The walk stops after a buffer with bit 15 set, or at a null link.
- R10: Command bit 15, or a link equal to 0 or 0xFFFFFFFF, ends the list after the current descriptor, and the unit returns to idle (0).
- R11: Command bit 14 puts the unit in the suspended state (1) after the descriptor and keeps the next pointer. A later start resumes from that pointer and ignores `list_head`.
- R12: Completing a descriptor with command bit 13 set sets `done_flag` and pulses `irq` for one cycle. Completing one with bit 13 clear clears `done_flag`.
- R13: While active (2), `start` is ignored. A start with no kept pointer and a null `list_head` is ignored. Memory and DMA requests occur only while active.
- R14: A DMA request holds `dma_addr` and `dma_len` stable until `dma_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or resume list processing |
| list_head | input | 32 | First descriptor address for a new list |
| link_up | input | 1 | Current link state reported by link test |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted/completed |
| dma_valid | output | 1 | Buffer transfer request |
| dma_addr | output | 32 | Buffer address |
| dma_len | output | 14 | Buffer length in bytes |
| dma_ready | input | 1 | DMA engine accepts request |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| done_flag | output | 1 | Last completed command asked for interrupt |
| irq | output | 1 | One-cycle interrupt pulse |
| ia_addr | output | 48 | Station address |
| cfg_flat | output | 112 | Configuration table, byte i at [8i+7:8i] |

## Verification
A corrupted descriptor pointer or link register shows within a few cycles as a status write to the wrong address. The bench compares every memory write and every DMA request against a queue built from the descriptors in memory, so a fault surfaces on the first wrong transaction, not at the end of the list. A wrong count or byte index in configure shows in the table contents once the list finishes. A lost suspend pointer shows on the next start, as the first busy write landing at the wrong place. Errors in the state register or the interrupt flag show as a wrong unit state, flag or pulse count as soon as the unit leaves the active state.

// File: rtl/cle_pkg.sv
package cle_pkg;
    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 16;
    localparam int CFG_BYTES = 14;
    localparam int CFG_IDX_W = $clog2(CFG_BYTES + 2);
    localparam int LEN_W     = 14;
    localparam int CNT_W     = 4;
    localparam int MIN_CFG   = 4;

    localparam logic [ADDR_W-1:0] PTR_NULL = '1;
    localparam logic [WORD_W-1:0] ST_BUSY  = 16'h4000;
    localparam logic [WORD_W-1:0] ST_DONE  = 16'hA000;
    localparam logic [WORD_W-1:0] LINK_ON  = 16'h8000;

    typedef enum logic [1:0] {
        CU_IDLE   = 2'd0,
        CU_SUSP   = 2'd1,
        CU_ACTIVE = 2'd2
    } cu_state_e;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0, OP_ADDR = 3'd1, OP_CFG  = 3'd2, OP_MCAST = 3'd3,
        OP_TX   = 3'd4, OP_LINK = 3'd5, OP_DUMP = 3'd6, OP_DIAG  = 3'd7
    } opcode_e;

    typedef struct packed {
        logic    last;
        logic    hold;
        logic    intr;
        opcode_e op;
    } cmd_t;

    typedef enum logic [4:0] {
        S_IDLE, S_MARK, S_CMD, S_LNK0, S_LNK1, S_DISP,
        S_ADDR, S_CFG, S_CFGFIX, S_LT0, S_LT1,
        S_TX0, S_TX1, S_TBCHK, S_TBSZ, S_TBN0, S_TBN1, S_TBA0, S_TBA1,
        S_DMA, S_FIN
    } seq_e;

    function automatic logic is_null(input logic [ADDR_W-1:0] ptr);
        return (ptr == '0) || (ptr == PTR_NULL);
    endfunction

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.last = w[15];
        c.hold = w[14];
        c.intr = w[13];
        c.op   = opcode_e'(w[2:0]);
        return c;
    endfunction

    function automatic logic [CFG_IDX_W-1:0] cfg_count(input logic [3:0] raw);
        logic [CFG_IDX_W-1:0] c;
        c = CFG_IDX_W'(raw);
        if (c < CFG_IDX_W'(MIN_CFG))   c = CFG_IDX_W'(MIN_CFG);
        if (c > CFG_IDX_W'(CFG_BYTES)) c = CFG_IDX_W'(CFG_BYTES);
        return c;
    endfunction
endpackage

// File: rtl/cle_station_regs.sv
module cle_station_regs
    import cle_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CFG_IDX_W-1:0]      cfg_idx,
    input  logic [1:0]                cfg_mask,
    input  logic [WORD_W-1:0]         cfg_wdata,
    input  logic                      cfg_fix,
    input  logic                      ia_we,
    input  logic [1:0]                ia_idx,
    input  logic [WORD_W-1:0]         ia_wdata,
    output logic [CFG_BYTES*8-1:0]    cfg_flat,
    output logic [47:0]               ia_addr
);
    logic [7:0]        tbl  [CFG_BYTES];
    logic [WORD_W-1:0] ia_w [3];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++) tbl[i] <= '0;
        end else if (cfg_fix) begin
            tbl[2]  <= (tbl[2] & 8'h82) | 8'h40;
            tbl[7]  <= tbl[7] & 8'hF7;
            tbl[10] <= (tbl[10] < 8'd5) ? 8'd5 : tbl[10];
            tbl[12] <= tbl[12] & 8'h40;
            tbl[13] <= tbl[13] | 8'h3F;
        end else if (cfg_we) begin
            for (int i = 0; i < CFG_BYTES; i++) begin
                if (cfg_mask[1] && (CFG_IDX_W'(i) == cfg_idx))
                    tbl[i] <= cfg_wdata[15:8];
                if (cfg_mask[0] && (CFG_IDX_W'(i) == cfg_idx + CFG_IDX_W'(1)))
                    tbl[i] <= cfg_wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) ia_w[i] <= '0;
        end else if (ia_we) begin
            for (int i = 0; i < 3; i++)
                if (2'(i) == ia_idx) ia_w[i] <= ia_wdata;
        end
    end

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_flat
        assign cfg_flat[8*g +: 8] = tbl[g];
    end
    assign ia_addr = {ia_w[0], ia_w[1], ia_w[2]};

    // R7: the forced bits are in place the cycle after a fixup
    a_r7_fixup_applied: assert property (@(posedge clk) disable iff (rst)
        cfg_fix |=> (tbl[2][6] && (tbl[2][5:2] == 4'h0) && !tbl[2][0] &&
                     !tbl[7][3] && (tbl[10] >= 8'd5) &&
                     ((tbl[12] & 8'hBF) == 8'h00) && (tbl[13][5:0] == 6'h3F)));
endmodule

// File: rtl/cle_cu_ctrl.sv
module cle_cu_ctrl
    import cle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      fin,
    input  cmd_t      fin_cmd,
    input  logic      fin_last,
    output cu_state_e cu_state,
    output logic      done_flag,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cu_state  <= CU_IDLE;
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (go) begin
                cu_state <= CU_ACTIVE;
            end else if (fin) begin
                done_flag <= fin_cmd.intr;
                irq       <= fin_cmd.intr;
                if (fin_cmd.hold)  cu_state <= CU_SUSP;
                else if (fin_last) cu_state <= CU_IDLE;
            end
        end
    end

    // R11: a completed descriptor with the suspend bit leaves the unit suspended
    a_r11_suspend_state: assert property (@(posedge clk) disable iff (rst)
        (fin && fin_cmd.hold) |=> (cu_state == CU_SUSP));

    // R12: the flag follows the interrupt bit of the descriptor just completed
    a_r12_flag_follows: assert property (@(posedge clk) disable iff (rst)
        fin |=> (done_flag == $past(fin_cmd.intr)) && (irq == $past(fin_cmd.intr)));
endmodule

// File: rtl/cmd_list_exec.sv
module cmd_list_exec
    import cle_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [31:0]            list_head,
    input  logic                   link_up,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [31:0]            mem_addr,
    output logic [15:0]            mem_wdata,
    input  logic [15:0]            mem_rdata,
    input  logic                   mem_ack,
    output logic                   dma_valid,
    output logic [31:0]            dma_addr,
    output logic [13:0]            dma_len,
    input  logic                   dma_ready,
    output logic [1:0]             cu_state,
    output logic                   done_flag,
    output logic                   irq,
    output logic [47:0]            ia_addr,
    output logic [111:0]           cfg_flat
);
    seq_e                 seq;
    cmd_t                 cmd;
    logic [ADDR_W-1:0]    cur_p, link_p, saved_p, tbd_p, tb_next, tb_addr;
    logic [LEN_W-1:0]     tb_len;
    logic                 tb_eof;
    logic [CNT_W-1:0]     k;
    logic [CFG_IDX_W-1:0] cfg_n;
    cu_state_e            cu_q;

    logic                 adv, go, fin;
    logic [ADDR_W-1:0]    start_p, next_p;
    logic [CFG_IDX_W-1:0] byte_idx, cfg_n_eff;
    logic [ADDR_W-1:0]    param_a;

    assign adv      = mem_req && mem_ack;
    assign start_p  = is_null(saved_p) ? list_head : saved_p;
    assign go       = (seq == S_IDLE) && start && (cu_q != CU_ACTIVE) && !is_null(start_p);
    assign fin      = (seq == S_FIN) && adv;
    assign next_p   = (cmd.last || is_null(link_p)) ? PTR_NULL : link_p;
    assign byte_idx = CFG_IDX_W'({k, 1'b0});
    assign param_a  = cur_p + 32'd8 + {27'd0, k, 1'b0};
    assign cfg_n_eff = (k == '0) ? cfg_count(mem_rdata[11:8]) : cfg_n;

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur_p;
        mem_wdata = '0;
        unique case (seq)
            S_MARK:         begin mem_we = 1'b1; mem_wdata = ST_BUSY; end
            S_CMD:          mem_addr = cur_p + 32'd2;
            S_LNK0:         mem_addr = cur_p + 32'd4;
            S_LNK1:         mem_addr = cur_p + 32'd6;
            S_ADDR, S_CFG:  mem_addr = param_a;
            S_LT0:          begin mem_we = 1'b1; mem_addr = cur_p + 32'd8;
                                  mem_wdata = link_up ? LINK_ON : 16'h0000; end
            S_LT1:          begin mem_we = 1'b1; mem_addr = cur_p + 32'd10; end
            S_TX0:          mem_addr = cur_p + 32'd8;
            S_TX1:          mem_addr = cur_p + 32'd10;
            S_TBSZ:         mem_addr = tbd_p;
            S_TBN0:         mem_addr = tbd_p + 32'd4;
            S_TBN1:         mem_addr = tbd_p + 32'd6;
            S_TBA0:         mem_addr = tbd_p + 32'd8;
            S_TBA1:         mem_addr = tbd_p + 32'd10;
            S_FIN:          begin mem_we = 1'b1; mem_wdata = ST_DONE; end
            default:        mem_req = 1'b0;
        endcase
    end

    assign dma_valid = (seq == S_DMA) && (tb_len != '0);
    assign dma_addr  = tb_addr;
    assign dma_len   = tb_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq     <= S_IDLE;
            cmd     <= '0;
            cur_p   <= '0;
            link_p  <= '0;
            saved_p <= PTR_NULL;
            tbd_p   <= '0;
            tb_next <= '0;
            tb_addr <= '0;
            tb_len  <= '0;
            tb_eof  <= 1'b0;
            k       <= '0;
            cfg_n   <= '0;
        end else begin
            unique case (seq)
                S_IDLE: if (go) begin
                    cur_p   <= start_p;
                    saved_p <= PTR_NULL;
                    seq     <= S_MARK;
                end
                S_MARK: if (adv) seq <= S_CMD;
                S_CMD:  if (adv) begin cmd <= decode_cmd(mem_rdata); seq <= S_LNK0; end
                S_LNK0: if (adv) begin link_p[15:0]  <= mem_rdata; seq <= S_LNK1; end
                S_LNK1: if (adv) begin link_p[31:16] <= mem_rdata; k <= '0; seq <= S_DISP; end
                S_DISP: begin
                    unique case (cmd.op)
                        OP_ADDR: seq <= S_ADDR;
                        OP_CFG:  seq <= S_CFG;
                        OP_LINK: seq <= S_LT0;
                        OP_TX:   seq <= S_TX0;
                        default: seq <= S_FIN;
                    endcase
                end
                S_ADDR: if (adv) begin
                    k <= k + 1'b1;
                    if (k == CNT_W'(2)) seq <= S_FIN;
                end
                S_CFG: if (adv) begin
                    k <= k + 1'b1;
                    if (k == '0) cfg_n <= cfg_n_eff;
                    if (byte_idx + CFG_IDX_W'(2) >= cfg_n_eff) seq <= S_CFGFIX;
                end
                S_CFGFIX: seq <= S_FIN;
                S_LT0:  if (adv) seq <= S_LT1;
                S_LT1:  if (adv) seq <= S_FIN;
                S_TX0:  if (adv) begin tbd_p[15:0]  <= mem_rdata; seq <= S_TX1; end
                S_TX1:  if (adv) begin tbd_p[31:16] <= mem_rdata; seq <= S_TBCHK; end
                S_TBCHK: seq <= is_null(tbd_p) ? S_FIN : S_TBSZ;
                S_TBSZ: if (adv) begin
                    tb_len <= mem_rdata[LEN_W-1:0];
                    tb_eof <= mem_rdata[15];
                    seq    <= S_TBN0;
                end
                S_TBN0: if (adv) begin tb_next[15:0]  <= mem_rdata; seq <= S_TBN1; end
                S_TBN1: if (adv) begin tb_next[31:16] <= mem_rdata; seq <= S_TBA0; end
                S_TBA0: if (adv) begin tb_addr[15:0]  <= mem_rdata; seq <= S_TBA1; end
                S_TBA1: if (adv) begin tb_addr[31:16] <= mem_rdata; seq <= S_DMA; end
                S_DMA: if ((tb_len == '0) || dma_ready) begin
                    if (tb_eof) seq <= S_FIN;
                    else begin tbd_p <= tb_next; seq <= S_TBCHK; end
                end
                S_FIN: if (adv) begin
                    if (cmd.hold) begin
                        saved_p <= next_p;
                        seq     <= S_IDLE;
                    end else if (is_null(next_p)) begin
                        saved_p <= PTR_NULL;
                        seq     <= S_IDLE;
                    end else begin
                        cur_p <= next_p;
                        seq   <= S_MARK;
                    end
                end
                default: seq <= S_IDLE;
            endcase
        end
    end

    cle_station_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    ((seq == S_CFG) && adv),
        .cfg_idx   (byte_idx),
        .cfg_mask  ({byte_idx < cfg_n_eff, (byte_idx + CFG_IDX_W'(1)) < cfg_n_eff}),
        .cfg_wdata (mem_rdata),
        .cfg_fix   (seq == S_CFGFIX),
        .ia_we     ((seq == S_ADDR) && adv),
        .ia_idx    (k[1:0]),
        .ia_wdata  (mem_rdata),
        .cfg_flat  (cfg_flat),
        .ia_addr   (ia_addr)
    );

    cle_cu_ctrl u_cu (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .fin       (fin),
        .fin_cmd   (cmd),
        .fin_last  (is_null(next_p)),
        .cu_state  (cu_q),
        .done_flag (done_flag),
        .irq       (irq)
    );

    assign cu_state = cu_q;

    // R2: an unacknowledged memory request is held unchanged
    a_r2_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R14: an unaccepted DMA request is held unchanged
    a_r14_dma_hold: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_len)));

    // R13: no memory or DMA traffic unless the unit is active
    a_r13_quiet_unless_active: assert property (@(posedge clk) disable iff (rst)
        (mem_req || dma_valid) |-> (cu_q == CU_ACTIVE));
endmodule

// File: tb/sim_cmd_list_exec.sv
module sim_cmd_list_exec;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  list_head = '0;
    logic         link_up = 1'b1;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [15:0]  mem_wdata, mem_rdata;
    logic         dma_valid, dma_ready;
    logic [31:0]  dma_addr;
    logic [13:0]  dma_len;
    logic [1:0]   cu_state;
    logic         done_flag, irq;
    logic [47:0]  ia_addr;
    logic [111:0] cfg_flat;

    always #2 clk = ~clk;

    cmd_list_exec u0 (
        .clk(clk), .rst(rst), .start(start), .list_head(list_head), .link_up(link_up),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_len(dma_len), .dma_ready(dma_ready),
        .cu_state(cu_state), .done_flag(done_flag), .irq(irq),
        .ia_addr(ia_addr), .cfg_flat(cfg_flat)
    );

    // memory: zero-wait, acknowledged in the request cycle
    logic [15:0] mem [0:4095];
    logic        tb_we = 1'b0;
    logic [31:0] tb_a = '0;
    logic [15:0] tb_d = '0;
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[12:1]];
    always @(posedge clk) begin
        if (tb_we) mem[tb_a[12:1]] <= tb_d;
        if (mem_req && mem_we) mem[mem_addr[12:1]] <= mem_wdata;
    end

    // DMA engine with a stall pattern; changes at posedge, stable at negedge
    int unsigned cyc = 0;
    logic        dma_rdy_q = 1'b0;
    always @(posedge clk) begin
        cyc       <= cyc + 1;
        dma_rdy_q <= (cyc % 3) == 2;
    end
    assign dma_ready = dma_rdy_q;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    localparam logic [31:0] NUL = 32'hFFFF_FFFF;
    logic [47:0] exp_wr[$];
    logic [45:0] exp_dma[$];
    logic [7:0]  m_cfg [14];
    logic [47:0] m_ia = '0;
    logic [1:0]  m_cu = 2'd0;
    logic        m_flag = 1'b0;
    int          m_irq = 0;
    int          seen_irq = 0;
    logic [31:0] m_saved = NUL;

    function automatic logic [15:0] rd(input logic [31:0] a);
        return mem[a[12:1]];
    endfunction
    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {rd(a + 32'd2), rd(a)};
    endfunction
    function automatic bit nul(input logic [31:0] p);
        return (p == 32'd0) || (p == NUL);
    endfunction

    task automatic model_start(input logic [31:0] head);
        logic [31:0] p, lnk, nxt, t, nx, ad;
        logic [15:0] c, w, sz;
        int n;
        p = nul(m_saved) ? head : m_saved;
        if (nul(p)) return;
        m_saved = NUL;
        forever begin
            exp_wr.push_back({p, 16'h4000});
            c   = rd(p + 32'd2);
            lnk = rd32(p + 32'd4);
            case (c[2:0])
                3'd1: m_ia = {rd(p + 32'd8), rd(p + 32'd10), rd(p + 32'd12)};
                3'd2: begin
                    w = rd(p + 32'd8);
                    n = int'(w[11:8]);
                    if (n < 4)  n = 4;
                    if (n > 14) n = 14;
                    for (int i = 0; i < n; i++) begin
                        w = rd(p + 32'd8 + 32'(i & ~1));
                        m_cfg[i] = (i % 2 == 0) ? w[15:8] : w[7:0];
                    end
                    m_cfg[2]  = (m_cfg[2] & 8'h82) | 8'h40;
                    m_cfg[7]  = m_cfg[7] & 8'hF7;
                    if (m_cfg[10] < 8'd5) m_cfg[10] = 8'd5;
                    m_cfg[12] = m_cfg[12] & 8'h40;
                    m_cfg[13] = m_cfg[13] | 8'h3F;
                end
                3'd5: begin
                    exp_wr.push_back({p + 32'd8, link_up ? 16'h8000 : 16'h0000});
                    exp_wr.push_back({p + 32'd10, 16'h0000});
                end
                3'd4: begin
                    t = rd32(p + 32'd8);
                    while (!nul(t)) begin
                        sz = rd(t);
                        nx = rd32(t + 32'd4);
                        ad = rd32(t + 32'd8);
                        if (sz[13:0] != 14'd0) exp_dma.push_back({ad, sz[13:0]});
                        if (sz[15]) break;
                        t = nx;
                    end
                end
                default: ;
            endcase
            exp_wr.push_back({p, 16'hA000});
            nxt    = (c[15] || nul(lnk)) ? NUL : lnk;
            m_flag = c[13];
            if (c[13]) m_irq++;
            if (c[14]) begin m_cu = 2'd1; m_saved = nxt; break; end
            if (nul(nxt)) begin m_cu = 2'd0; break; end
            p = nxt;
        end
    endtask

    // per-clock comparison of every write and DMA hand-off
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_we) begin
                if (exp_wr.size() == 0) chk("R3", "unexpected write", {mem_addr, mem_wdata}, '0);
                else begin
                    automatic logic [47:0] e = exp_wr.pop_front();
                    chk((e[15:0] == 16'h4000 || e[15:0] == 16'hA000) ? "R3" : "R8",
                        "write addr/data", {mem_addr, mem_wdata}, e);
                end
            end
            if (dma_valid && dma_ready) begin
                if (exp_dma.size() == 0) chk("R9", "unexpected dma", {dma_addr, dma_len}, '0);
                else chk("R9", "dma addr/len", {dma_addr, dma_len}, exp_dma.pop_front());
            end
            if (irq) seen_irq++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic poke(input logic [31:0] a, input logic [15:0] d);
        tb_a = a; tb_d = d; tb_we = 1'b1;
        @(negedge clk);
        tb_we = 1'b0;
    endtask
    task automatic poke32(input logic [31:0] a, input logic [31:0] v);
        poke(a, v[15:0]);
        poke(a + 32'd2, v[31:16]);
    endtask
    task automatic desc(input logic [31:0] p, input logic [15:0] c, input logic [31:0] lnk);
        poke(p, 16'h0000);
        poke(p + 32'd2, c);
        poke32(p + 32'd4, lnk);
    endtask
    task automatic tbd(input logic [31:0] t, input logic [15:0] sz,
                       input logic [31:0] nx, input logic [31:0] ad);
        poke(t, sz);
        poke32(t + 32'd4, nx);
        poke32(t + 32'd8, ad);
    endtask

    task automatic run_list(input logic [31:0] head, input string tag);
        int guard;
        model_start(head);
        list_head = head;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (cu_state == 2'd2 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        chk("R3", {tag, " writes left"}, 64'(exp_wr.size()), 0);
        chk("R9", {tag, " dma left"}, 64'(exp_dma.size()), 0);
        chk("R10", {tag, " unit state"}, 64'(cu_state), 64'(m_cu));
        chk("R12", {tag, " done flag"}, 64'(done_flag), 64'(m_flag));
        chk("R12", {tag, " irq count"}, 64'(seen_irq), 64'(m_irq));
        chk("R5", {tag, " station addr"}, 64'(ia_addr), 64'(m_ia));
        for (int i = 0; i < 14; i++)
            chk("R6", $sformatf("%s cfg byte %0d", tag, i), 64'(cfg_flat[8*i +: 8]), 64'(m_cfg[i]));
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 14; i++) m_cfg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cu_state", 64'(cu_state), 0);
        chk("R1", "mem_req", 64'(mem_req), 0);
        chk("R1", "dma_valid", 64'(dma_valid), 0);
        chk("R1", "irq/done", 64'({irq, done_flag}), 0);
        chk("R1", "ia_addr", 64'(ia_addr), 0);
        chk("R1", "cfg low", cfg_flat[63:0], 0);
        chk("R1", "cfg high", 64'(cfg_flat[111:64]), 0);

        // list A: no-op(intr) -> addr load -> configure(count 0) -> link test -> transmit(last, intr)
        desc(32'h100, 16'h2000, 32'h120);
        desc(32'h120, 16'h0001, 32'h140);
        poke(32'h128, 16'h0211); poke(32'h12A, 16'h2233); poke(32'h12C, 16'h4455);
        desc(32'h140, 16'h0002, 32'h160);
        poke(32'h148, 16'h10AB); poke(32'h14A, 16'hFF5A); poke(32'h14C, 16'h7777);
        desc(32'h160, 16'h0005, 32'h180);
        desc(32'h180, 16'hA004, 32'h1A0);
        poke32(32'h188, 32'h400);
        tbd(32'h400, 16'h0040, 32'h410, 32'h1000_0000);
        tbd(32'h410, 16'h0000, 32'h420, 32'h1100_0000);   // empty buffer skipped (R9)
        tbd(32'h420, 16'h8005, 32'h430, 32'h2000_0004);   // last buffer (R9)
        tbd(32'h430, 16'h0033, 32'hFFFF_FFFF, 32'h3300_0000);
        run_list(32'h100, "R4 R5 R6 R7 R8 R9 list A");

        // configure with count 15, clamped to 14 (R6, R7); interrupt bit clear (R12)
        desc(32'h200, 16'h8002, 32'h0);
        poke(32'h208, 16'h0F11); poke(32'h20A, 16'hFF33); poke(32'h20C, 16'h4455);
        poke(32'h20E, 16'h66FF); poke(32'h210, 16'h8899); poke(32'h212, 16'h02BB);
        poke(32'h214, 16'hFFDD); poke(32'h216, 16'hEEEE);
        run_list(32'h200, "R6 R7 R12 long cfg");
        chk("R7", "byte 12 keeps bit 6", 64'(cfg_flat[8*12 +: 8]), 64'h40);
        chk("R7", "byte 10 raised", 64'(cfg_flat[8*10 +: 8]), 64'h05);

        // suspend then resume from the kept pointer (R11), link down test (R8)
        desc(32'h300, 16'h6000, 32'h320);
        desc(32'h320, 16'h8005, 32'h0);
        desc(32'h700, 16'h8000, 32'h0);
        run_list(32'h300, "R11 suspend");
        chk("R11", "suspended state", 64'(cu_state), 1);
        link_up = 1'b0;
        run_list(32'h700, "R11 R8 resume");
        chk("R11", "kept pointer used", 64'(mem[12'h320 >> 1]), 64'hA000);
        chk("R11", "head not used", 64'(mem[12'h700 >> 1]), 64'h0000);
        link_up = 1'b1;

        // diagnose opcode as no-op, transmit ended by null buffer link, zero list link (R4, R9, R10)
        desc(32'h4E0, 16'h0007, 32'h500);
        desc(32'h500, 16'h0004, 32'h0);
        poke32(32'h508, 32'h600);
        tbd(32'h600, 16'h0010, 32'hFFFF_FFFF, 32'h0000_3000);
        run_list(32'h4E0, "R4 R9 R10 zero link");

        // null head with nothing kept: start ignored (R13)
        list_head = 32'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13", "null start ignored", 64'(cu_state), 0);
        chk("R13", "no traffic", 64'(exp_wr.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule